// File: doc/BRIEF.md
# ADC Output Word Formatter

This block turns each signed conversion result from an analog-to-digital converter into the 24-bit word that the serial output stage sends. For every accepted sample it does three things. It picks the number coding, which is either straight binary (offset) or two's complement. It can scramble the result bits so that the data on the lanes are less correlated with the analog signal. It then appends a short field of user-defined bits, and the receiver can use this field to identify the channel group or to check lane alignment.

Two scrambling modes are available. In PRBS mode a pseudo-random bit goes directly after the result's LSB, and every result bit is XORed with that bit. In LSB mode every result bit above the LSB is XORed with the LSB, which itself passes through unchanged. Because of this the receiver can recover the data from the word alone. Samples come in and words go out over valid/ready streams. A word waits in the single output register until the consumer takes it. While that register is full and not being taken, the input is not accepted.

Top module: `wfmt_top`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and the scrambler state is all ones, so the first scramble bit is 1.
- R2: With `cfg_twos`=1 and scrambling off, `out_word[23:6]` equals `in_result` bit for bit.
- R3: With `cfg_twos`=0 and scrambling off, `out_word[23:6]` is the straight-binary code, which is `in_result` + 131072 modulo 2^18 (the MSB inverted).
- R4: When scrambling is off, or in LSB mode, `out_word[5:0]` is `cfg_user_hi` if `in_group`=1 and `cfg_user_lo` if `in_group`=0.
- R5: With `cfg_scr_en`=1 and `cfg_scr_lsb`=0 (PRBS mode), `out_word[23:6]` is the coded result XOR the scramble bit p in every position, `out_word[5]` = p, and `out_word[4:0]` is the low 5 bits of the selected user field.
- R6: With `cfg_scr_en`=1 and `cfg_scr_lsb`=1 (LSB mode), `out_word[6]` is the coded LSB, and `out_word[23:7]` is coded bits 17..1 each XORed with that LSB.
- R7: The scrambler is a 15-bit shift register with polynomial x^15+x^14+1. The scramble bit p is state bit 14. On each accepted sample, in any mode, the state shifts left and the new bit 0 is bit14 XOR bit13. The state never changes on any other cycle.
- R8: A sample accepted on a clock edge (`in_valid` and `in_ready` both 1) shows up in `out_word` with `out_valid`=1 right after that edge. A cycle with `in_ready`=1 and `in_valid`=0 leaves `out_valid`=0.
- R9: `in_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, the word stays unchanged and no sample is accepted.
- R10: The configuration inputs are sampled only at acceptance. Changing them while a word is waiting has no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_result | input | 18 | Signed conversion result (two's complement) |
| in_group | input | 1 | Channel group of the sample: 0 selects the low user field, 1 the high |
| cfg_twos | input | 1 | 1 = two's-complement coding, 0 = straight binary |
| cfg_scr_en | input | 1 | Scrambling enable |
| cfg_scr_lsb | input | 1 | Scramble mode: 0 = PRBS bit, 1 = result LSB |
| cfg_user_lo | input | 6 | User bits for the low channel group |
| cfg_user_hi | input | 6 | User bits for the high channel group |
| out_valid | output | 1 | Formatted word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 24 | Formatted word, result MSB in bit 23 |

## Verification
Some properties are checked by assertions on every cycle. These are the stream rules: the stall blocks input, the stalled word holds, an accepted sample is followed by a valid output, and an idle input gives no output. The assertions also check that the LSB survives LSB mode, that two's-complement pass-through is exact, and that the scrambler state is never zero and moves only on acceptance. Other behaviour can only be shown by the bench's scenarios. That covers the exact scrambled values along the PRBS sequence, the offset coding at the range ends, the placement of the user field for each group and mode, and the fact that configuration changes made during a stall are ignored.

// File: rtl/wfmt_pkg.sv
package wfmt_pkg;
  localparam int RES_W    = 18;
  localparam int USR_W    = 6;
  localparam int WORD_W   = RES_W + USR_W;
  localparam int PRBS_LEN = 15;
  localparam int PRBS_TAP = 14;

  typedef enum logic {
    SCR_PRBS = 1'b0,
    SCR_LSB  = 1'b1
  } scr_mode_e;
endpackage

// File: rtl/wfmt_prbs.sv
module wfmt_prbs #(
  parameter int LEN = 15,
  parameter int TAP = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic bit_o
);
  logic [LEN-1:0] state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= '1;
    end else if (step) begin
      state <= {state[LEN-2:0], state[LEN-1] ^ state[TAP-1]};
    end
  end

  assign bit_o = state[LEN-1];

  // R7: a maximal-length register never reaches the all-zero lock-up state
  assert_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R7: the sequence moves only on accepted samples
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));
endmodule

// File: rtl/wfmt_encode.sv
module wfmt_encode
  import wfmt_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int UW = USR_W,
  localparam int WW = RW + UW
) (
  input  logic [RW-1:0] res,
  input  logic          twos,
  input  logic          scr_en,
  input  scr_mode_e     scr_mode,
  input  logic [UW-1:0] usr,
  input  logic          pbit,
  output logic [WW-1:0] word
);
  logic [RW-1:0] coded;
  logic [RW-1:0] mask_prbs;
  logic [RW-1:0] mask_lsb;

  // offset coding flips only the sign bit
  assign coded = {res[RW-1] ^ ~twos, res[RW-2:0]};

  for (genvar i = 0; i < RW; i++) begin : g_mask
    assign mask_prbs[i] = pbit;
    if (i == 0) begin : g_keep
      assign mask_lsb[i] = 1'b0;
    end else begin : g_flip
      assign mask_lsb[i] = coded[0];
    end
  end

  always_comb begin
    word = {coded, usr};
    if (scr_en) begin
      if (scr_mode == SCR_LSB) begin
        word = {coded ^ mask_lsb, usr};
      end else begin
        word = {coded ^ mask_prbs, pbit, usr[UW-2:0]};
      end
    end
  end
endmodule

// File: rtl/wfmt_top.sv
module wfmt_top
  import wfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RES_W-1:0]  in_result,
  input  logic              in_group,
  input  logic              cfg_twos,
  input  logic              cfg_scr_en,
  input  logic              cfg_scr_lsb,
  input  logic [USR_W-1:0]  cfg_user_lo,
  input  logic [USR_W-1:0]  cfg_user_hi,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  logic              take;
  logic              pbit;
  logic [USR_W-1:0]  usr_sel;
  logic [WORD_W-1:0] next_word;
  scr_mode_e         mode;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign usr_sel  = in_group ? cfg_user_hi : cfg_user_lo;
  assign mode     = cfg_scr_lsb ? SCR_LSB : SCR_PRBS;

  wfmt_prbs #(.LEN(PRBS_LEN), .TAP(PRBS_TAP)) u_prbs (
    .clk  (clk),
    .rst_n(rst_n),
    .step (take),
    .bit_o(pbit)
  );

  wfmt_encode #(.RW(RES_W), .UW(USR_W)) u_enc (
    .res     (in_result),
    .twos    (cfg_twos),
    .scr_en  (cfg_scr_en),
    .scr_mode(mode),
    .usr     (usr_sel),
    .pbit    (pbit),
    .word    (next_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_word  <= next_word;
    end
  end

  // R9: a waiting word blocks the input
  assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: a waiting word is held
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R8: one-cycle latency from acceptance
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R8: no input, no output
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);

  // R6: LSB mode leaves the result LSB in place
  assert_lsb_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cfg_scr_en && cfg_scr_lsb) |=> out_word[USR_W] == $past(in_result[0]));

  // R2: two's complement, unscrambled, is a straight copy
  assert_twos_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cfg_scr_en && cfg_twos) |=> out_word[WORD_W-1:USR_W] == $past(in_result));
endmodule

// File: tb/wfmt_top_test.sv
`timescale 1ns/1ps
module wfmt_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_result = '0;
  logic        in_group = 1'b0;
  logic        cfg_twos = 1'b1;
  logic        cfg_scr_en = 1'b0;
  logic        cfg_scr_lsb = 1'b0;
  logic [5:0]  cfg_user_lo = 6'h2D;
  logic [5:0]  cfg_user_hi = 6'h12;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_word;

  int total = 0;
  int bad = 0;
  logic [14:0] model = '1;
  logic [31:0] rnd = 32'h1234_5678;

  always #2 clk = ~clk;

  wfmt_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_result(in_result), .in_group(in_group), .cfg_twos(cfg_twos),
    .cfg_scr_en(cfg_scr_en), .cfg_scr_lsb(cfg_scr_lsb),
    .cfg_user_lo(cfg_user_lo), .cfg_user_hi(cfg_user_hi),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_word(input logic [17:0] r, input logic twos,
      input logic en, input logic lsb, input logic grp, input logic [5:0] ulo,
      input logic [5:0] uhi, input logic p);
    logic [17:0] c;
    logic [5:0]  u;
    logic [17:0] s;
    c = twos ? r : 18'(r + 18'd131072);
    u = grp ? uhi : ulo;
    if (!en) return {c, u};
    if (lsb) begin
      s = c;
      for (int i = 1; i < 18; i++) s[i] = c[i] ^ c[0];
      return {s, u};
    end
    for (int i = 0; i < 18; i++) s[i] = c[i] ^ p;
    return {s, p, u[4:0]};
  endfunction

  function automatic string tag_of(input logic twos, input logic en, input logic lsb);
    if (!en) return twos ? "R2/R4" : "R3/R4";
    return lsb ? "R6/R4" : "R5/R7";
  endfunction

  function automatic logic [17:0] val_of(input int i);
    case (i)
      0: return 18'h00000;
      1: return 18'h00001;
      2: return 18'h3FFFF;
      3: return 18'h1FFFF;
      4: return 18'h20000;
      5: return 18'h15555;
      6: return 18'h2AAAA;
      7: return 18'h00100;
      8: return 18'h3FF00;
      default: return 18'(i * 7919);
    endcase
  endfunction

  // drive at a falling edge, accepted at the rising edge, checked at the next falling edge
  task automatic send_one(input logic [17:0] r);
    logic [23:0] e;
    in_result = r;
    in_valid  = 1'b1;
    out_ready = 1'b1;
    e = expect_word(r, cfg_twos, cfg_scr_en, cfg_scr_lsb, in_group, cfg_user_lo, cfg_user_hi, model[14]);
    @(negedge clk);
    model = {model[13:0], model[14] ^ model[13]};
    check("R8 valid", {23'd0, out_valid}, 24'd1);
    check(tag_of(cfg_twos, cfg_scr_en, cfg_scr_lsb), out_word, e);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] held;
    logic [23:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid", {23'd0, out_valid}, 24'd0);
    check("R1 in_ready", {23'd0, in_ready}, 24'd1);

    // R7 seed: first scramble bit is 1
    cfg_scr_en = 1'b1; cfg_scr_lsb = 1'b0; cfg_twos = 1'b1; in_group = 1'b0;
    send_one(18'h00000);
    check("R1/R7 seed bit", {23'd0, out_word[5]}, 24'd1);

    // sweep all configurations over corner values
    for (int c = 0; c < 16; c++) begin
      cfg_twos = c[0]; cfg_scr_en = c[1]; cfg_scr_lsb = c[2]; in_group = c[3];
      for (int v = 0; v < 14; v++) send_one(val_of(v));
    end

    // pseudo-random stream with changing fields
    for (int k = 0; k < 1500; k++) begin
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      cfg_twos = rnd[18]; cfg_scr_en = rnd[19]; cfg_scr_lsb = rnd[20]; in_group = rnd[21];
      cfg_user_lo = rnd[27:22]; cfg_user_hi = {rnd[31:28], rnd[1:0]};
      send_one(rnd[17:0]);
    end

    // idle cycle: no output (R8)
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 idle", {23'd0, out_valid}, 24'd0);

    // stall with a PRBS-mode word, then change everything (R9, R10, R7)
    cfg_twos = 1'b0; cfg_scr_en = 1'b1; cfg_scr_lsb = 1'b0; in_group = 1'b1;
    cfg_user_hi = 6'h3A;
    in_result = 18'h0ABCD; in_valid = 1'b1; out_ready = 1'b0;
    e = expect_word(18'h0ABCD, 1'b0, 1'b1, 1'b0, 1'b1, cfg_user_lo, 6'h3A, model[14]);
    @(negedge clk);
    model = {model[13:0], model[14] ^ model[13]};
    check("R9 stalled word", out_word, e);
    held = out_word;
    in_result = 18'h31234; cfg_twos = 1'b1; cfg_scr_lsb = 1'b1; in_group = 1'b0; cfg_user_hi = 6'h05;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 in_ready low", {23'd0, in_ready}, 24'd0);
      check("R10 word unchanged", out_word, held);
    end
    // release: next sample in PRBS mode must use the very next sequence bit (R7)
    cfg_scr_lsb = 1'b0;
    out_ready = 1'b1;
    e = expect_word(18'h31234, 1'b1, 1'b1, 1'b0, 1'b0, cfg_user_lo, 6'h05, model[14]);
    @(negedge clk);
    model = {model[13:0], model[14] ^ model[13]};
    check("R7/R9 after stall", out_word, e);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 drain", {23'd0, out_valid}, 24'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule